// File: doc/BRIEF.md
# Shadow ROM Load and Activation Controller

This block decides when a RAM copy of the system ROM takes over the ROM address window. The local processor writes a complete image into the window. Each finished word write is counted. Once a full image has been written, a loaded flag is set. The switch itself waits for the next host reset. From that point the memory decoder serves ROM-window reads from the shadow RAM and ignores further writes, and an indicator output lights.

The image is dropped by holding the host reset for a long time, about one second by default. A held keyboard reset produces that. Both the loaded flag and the active redirect are cleared, so a new image can be written afterwards. A normal short reset leaves the state unchanged. Every reset clears the word counter, so an image that is cut off part way never counts as complete.

The block is placed beside the local memory decoder. It sees the processor address strobe, a decoded "write to ROM window" select and the host reset, all in the processor clock domain. Its outputs are write-capture and read-redirect enables for the decoder.

Top module: `shadow_rom_ctrl`

## Requirements
- R1: A write is counted when `romWrSel` is high during an `asN` low phase while `captureEn` is high. It is counted exactly once, at the rising edge of `asN`, however long `asN` stayed low. An `asN` low phase without `romWrSel` is not counted.
- R2: After IMAGE_WORDS counted writes, an internal loaded flag is set. `redirectEn` stays low until the next host reset. It then rises within 3 clock cycles of `rstN` going low.
- R3: `ledOn` and `redirectEn` are always equal. `captureEn` is always the inverse of `redirectEn`.
- R4: A host reset held low for at least HOLD_CYCLES + 2 clock cycles clears both the redirect and the loaded flag. A later short reset then does not activate redirect.
- R5: While redirect is active, `captureEn` is low and ROM-window writes are not counted. A further full set of writes leaves redirect active across a short reset.
- R6: Every host reset clears the word counter. A write whose `asN` rise falls in the cycle where the synchronised reset is first seen is not counted. A load that is short of IMAGE_WORDS before a reset never sets the loaded flag.
- R7: A host reset shorter than HOLD_CYCLES cycles leaves the redirect and loaded state unchanged.
- R8: After power-on reset (`porN` low), `redirectEn` is 0, `ledOn` is 0 and `captureEn` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| rstN | input | 1 | Host system reset, active low, synchronised inside |
| asN | input | 1 | Local processor address strobe, active low |
| romWrSel | input | 1 | Decoded write to the ROM window for the current cycle |
| captureEn | output | 1 | Decoder may steer ROM-window writes into shadow RAM |
| redirectEn | output | 1 | Decoder serves ROM-window reads from shadow RAM |
| ledOn | output | 1 | Indicator drive, high while redirect is active |

## Verification
The two functions that can meet in one cycle are the completion of the final image write and the recognition of a host reset. The bench provokes this by holding the last window write open across the two synchroniser stages of `rstN`. `asN` then rises in exactly the cycle where the synchronised reset first appears. Reset takes priority, so that write must be lost. The bench judges this at the ports: a following short reset must not switch redirect on, and a fresh full load followed by a reset must.

// File: rtl/shadow_rom_pkg.sv
package shadow_rom_pkg;

  // Events the datapath reports to the control
  typedef struct packed {
    logic imageFull;    // last word of the image has just been counted
    logic resetEnter;   // synchronised host reset has just asserted
    logic holdExpired;  // host reset has been held for the threshold
  } dp_evt_t;

  // Commands the control sends to the datapath
  typedef struct packed {
    logic captureEn;
  } ctl_cmd_t;

endpackage

// File: rtl/shadow_rom_datapath.sv
module shadow_rom_datapath
  import shadow_rom_pkg::*;
#(
  parameter int unsigned IMAGE_WORDS = 262144,
  parameter int unsigned HOLD_CYCLES = 40000000
) (
  input  logic     clk,
  input  logic     porN,
  input  logic     rstN,
  input  logic     asN,
  input  logic     romWrSel,
  input  ctl_cmd_t cmd,
  output dp_evt_t  evt
);

  localparam int unsigned CNT_W  = (IMAGE_WORDS > 1) ? $clog2(IMAGE_WORDS) : 1;
  localparam int unsigned HOLD_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0]  LAST_WORD = CNT_W'(IMAGE_WORDS - 1);
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_CYCLES - 1);
  localparam logic [HOLD_W-1:0] HOLD_MAX  = HOLD_W'(HOLD_CYCLES);

  // Two-stage synchroniser for the host reset (value 1 = released)
  logic rstMeta, rstSync, hostRst, rstPrev;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      rstMeta <= 1'b0;
      rstSync <= 1'b0;
      rstPrev <= 1'b1;
    end else begin
      rstMeta <= rstN;
      rstSync <= rstMeta;
      rstPrev <= hostRst;
    end
  end

  assign hostRst = !rstSync;

  // Word-write counter, advanced on the rising edge of the address strobe
  logic             asPrev, wrSeen, asRise, countEv;
  logic [CNT_W-1:0] wrCnt;

  assign asRise  = asN && !asPrev;
  assign countEv = asRise && wrSeen && !hostRst;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      asPrev <= 1'b1;
      wrSeen <= 1'b0;
      wrCnt  <= '0;
    end else begin
      asPrev <= asN;
      if (hostRst) begin
        wrSeen <= 1'b0;
        wrCnt  <= '0;
      end else begin
        if (asRise)
          wrSeen <= 1'b0;
        else if (!asN && romWrSel && cmd.captureEn)
          wrSeen <= 1'b1;
        if (countEv)
          wrCnt <= (wrCnt == LAST_WORD) ? '0 : wrCnt + 1'b1;
      end
    end
  end

  // Reset-hold timer, saturating at the threshold
  logic [HOLD_W-1:0] holdCnt;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)
      holdCnt <= '0;
    else if (!hostRst)
      holdCnt <= '0;
    else if (holdCnt != HOLD_MAX)
      holdCnt <= holdCnt + 1'b1;
  end

  assign evt.imageFull   = countEv && (wrCnt == LAST_WORD);
  assign evt.resetEnter  = hostRst && !rstPrev;
  assign evt.holdExpired = hostRst && (holdCnt == HOLD_LAST);

  // R6: a reset seen in one cycle leaves an empty counter in the next
  assert_clear_on_reset_R6: assert property (@(posedge clk) disable iff (!porN)
    hostRst |=> (wrCnt == '0));

  // R1: the counter moves only on a strobe rise outside reset
  assert_count_on_rise_R1: assert property (@(posedge clk) disable iff (!porN)
    (!hostRst && !asRise) |=> $stable(wrCnt));

  // R4: the hold timer never passes its threshold
  assert_hold_bound_R4: assert property (@(posedge clk) disable iff (!porN)
    holdCnt <= HOLD_MAX);

endmodule

// File: rtl/shadow_rom_control.sv
module shadow_rom_control
  import shadow_rom_pkg::*;
(
  input  logic     clk,
  input  logic     porN,
  input  dp_evt_t  evt,
  output ctl_cmd_t cmd,
  output logic     redirectOn
);

  logic loaded, redirect;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      loaded   <= 1'b0;
      redirect <= 1'b0;
    end else if (evt.holdExpired) begin
      loaded   <= 1'b0;
      redirect <= 1'b0;
    end else begin
      if (evt.imageFull)
        loaded <= 1'b1;
      if (evt.resetEnter && loaded)
        redirect <= 1'b1;
    end
  end

  assign cmd.captureEn = !redirect;
  assign redirectOn    = redirect;

  // R2: a loaded image is switched in at reset entry
  assert_activate_on_reset_R2: assert property (@(posedge clk) disable iff (!porN)
    (evt.resetEnter && loaded && !evt.holdExpired) |=> redirect);

  // R2: redirect never rises without a reset entry
  assert_no_early_redirect_R2: assert property (@(posedge clk) disable iff (!porN)
    (!redirect && !evt.resetEnter) |=> !redirect);

  // R1: loaded only follows a completed image
  assert_loaded_needs_image_R1: assert property (@(posedge clk) disable iff (!porN)
    (!loaded && !evt.imageFull) |=> !loaded);

  // R4: a long reset clears everything
  assert_deactivate_R4: assert property (@(posedge clk) disable iff (!porN)
    evt.holdExpired |=> (!redirect && !loaded));

endmodule

// File: rtl/shadow_rom_ctrl.sv
module shadow_rom_ctrl
  import shadow_rom_pkg::*;
#(
  parameter int unsigned IMAGE_WORDS = 262144,
  parameter int unsigned HOLD_CYCLES = 40000000
) (
  input  logic clk,
  input  logic porN,
  input  logic rstN,
  input  logic asN,
  input  logic romWrSel,
  output logic captureEn,
  output logic redirectEn,
  output logic ledOn
);

  dp_evt_t  evt;
  ctl_cmd_t cmd;
  logic     redirectOn;

  shadow_rom_datapath #(
    .IMAGE_WORDS(IMAGE_WORDS),
    .HOLD_CYCLES(HOLD_CYCLES)
  ) dp_i (
    .clk      (clk),
    .porN     (porN),
    .rstN     (rstN),
    .asN      (asN),
    .romWrSel (romWrSel),
    .cmd      (cmd),
    .evt      (evt)
  );

  shadow_rom_control ctl_i (
    .clk        (clk),
    .porN       (porN),
    .evt        (evt),
    .cmd        (cmd),
    .redirectOn (redirectOn)
  );

  assign captureEn  = cmd.captureEn;
  assign redirectEn = redirectOn;
  assign ledOn      = redirectOn;

  // R5: capture is never offered while redirect is live
  assert_no_capture_in_redirect_R5: assert property (@(posedge clk) disable iff (!porN)
    redirectEn |-> !captureEn);

endmodule

// File: tb/shadow_rom_ctrl_tb_top.sv
module shadow_rom_ctrl_tb_top;

  localparam int unsigned IMG  = 16;
  localparam int unsigned HOLD = 50;

  logic clk = 1'b0;
  logic porN = 1'b0, rstN = 1'b0, asN = 1'b1, romWrSel = 1'b0;
  logic captureEn, redirectEn, ledOn;
  int   checks = 0, errors = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  shadow_rom_ctrl #(.IMAGE_WORDS(IMG), .HOLD_CYCLES(HOLD)) dut_i (
    .clk(clk), .porN(porN), .rstN(rstN), .asN(asN), .romWrSel(romWrSel),
    .captureEn(captureEn), .redirectEn(redirectEn), .ledOn(ledOn)
  );

  typedef struct packed {
    logic [7:0] writes;
    logic       sel;
    logic [7:0] lowLen;
    logic [7:0] rstLen;
    logic       expRedir;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{8'd16, 1'b1, 8'd3, 8'd0,  1'b0},  // R2 loaded, not yet active
    '{8'd0,  1'b1, 8'd3, 8'd10, 1'b1},  // R2 active after reset
    '{8'd16, 1'b1, 8'd3, 8'd10, 1'b1},  // R5 writes ignored
    '{8'd0,  1'b1, 8'd3, 8'd80, 1'b0},  // R4 long reset
    '{8'd0,  1'b1, 8'd3, 8'd10, 1'b0},  // R4 loaded cleared too
    '{8'd15, 1'b1, 8'd3, 8'd10, 1'b0},  // R6 one word short
    '{8'd15, 1'b1, 8'd3, 8'd10, 1'b0},  // R6 counter was cleared
    '{8'd16, 1'b0, 8'd3, 8'd10, 1'b0},  // R1 outside window
    '{8'd8,  1'b1, 8'd6, 8'd10, 1'b0},  // R1 long strobe counts once
    '{8'd16, 1'b1, 8'd1, 8'd10, 1'b1},  // R1 shortest strobe
    '{8'd0,  1'b1, 8'd3, 8'd10, 1'b1},  // R7 short reset keeps state
    '{8'd0,  1'b1, 8'd3, 8'd80, 1'b0}   // R4 long reset again
  };

  function automatic string tagOf(int i);
    case (i)
      0, 1:       return "R2";
      2:          return "R5";
      3, 4, 11:   return "R4";
      5, 6:       return "R6";
      7, 8, 9:    return "R1";
      default:    return "R7";
    endcase
  endfunction

  task automatic check(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic checkOuts(string tag, logic expRedir);
    check(tag, "redirectEn", redirectEn, expRedir);
    check("R3", "ledOn", ledOn, expRedir);
    check("R3", "captureEn", captureEn, !expRedir);
  endtask

  task automatic doWrite(logic sel, int lowLen);
    @(negedge clk);
    asN = 1'b0; romWrSel = sel;
    repeat (lowLen) @(negedge clk);
    asN = 1'b1; romWrSel = 1'b0;
  endtask

  task automatic doReset(int len);
    @(negedge clk);
    rstN = 1'b0;
    repeat (len) @(negedge clk);
    rstN = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    porN = 1'b1;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    checkOuts("R8", 1'b0);

    for (int i = 0; i < NV; i++) begin
      for (int w = 0; w < int'(VECS[i].writes); w++)
        doWrite(VECS[i].sel, int'(VECS[i].lowLen));
      @(negedge clk);
      if (VECS[i].rstLen != 0) doReset(int'(VECS[i].rstLen));
      checkOuts(tagOf(i), VECS[i].expRedir);
    end

    // R2: redirect rises during the reset itself, within 3 cycles
    for (int w = 0; w < int'(IMG); w++) doWrite(1'b1, 2);
    @(negedge clk);
    check("R2", "redirect before reset", redirectEn, 1'b0);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R2", "redirect during reset", redirectEn, 1'b1);
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    doReset(80);
    checkOuts("R4", 1'b0);

    // R6: last write completes in the cycle the reset is first seen
    for (int w = 0; w < int'(IMG) - 1; w++) doWrite(1'b1, 2);
    @(negedge clk);
    asN = 1'b0; romWrSel = 1'b1;
    repeat (2) @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    asN = 1'b1; romWrSel = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check("R6", "redirect after colliding reset", redirectEn, 1'b0);
    doReset(10);
    check("R6", "colliding write not counted", redirectEn, 1'b0);
    for (int w = 0; w < int'(IMG); w++) doWrite(1'b1, 2);
    doReset(10);
    checkOuts("R2", 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule